// File: doc/BRIEF.md
# Circular Trace Capture Buffer

This block is a trace sink. It writes a stream of 32-bit trace words into an on-chip RAM that is used as a ring. A write pointer marks the next free word and a read pointer marks the next word that software will fetch. When the write pointer runs past the last word it wraps to zero and a sticky wrap flag is set. After that the oldest valid word sits at the write pointer and no longer at address 0.

Software reaches the block through a 32-bit register bus with a setup phase and an access phase. Through it software can set the pointers, load a post-trigger word count, and start or stop capture. Two data ports give RAM access: each access to one of them moves its own pointer forward by one word. There are two ways to end capture in an orderly way:
- Stop on trigger: capture ends a programmed number of words after a trigger pulse.
- Manual flush: a flush bit clears itself once the trace source acknowledges, and can optionally halt capture when it completes.

When formatting is enabled, capture never halts in the middle of a 4-word frame. The block first pads the frame with zero words.

Top module: `trace_ring_sink`

## Requirements
- R1: After reset the depth register (byte offset 0x004) reads DEPTH with bit 31 clear, and status (0x00C), control (0x020), the read pointer (0x014) and the write pointer (0x018) all read 0. Formatter status (0x300) reads 0x2: bit 1 means "stopped".
- R2: The trigger count (0x01C), the control register (bit 0 = run) and formatter control (0x304) read back what was written to them. Formatter control uses bit 0 for format enable, bit 12 for stop-on-flush and bit 13 for stop-on-trigger. A pointer write keeps only the low log2(DEPTH) bits of the written value, and writes to the depth register are ignored.
- R3: A write to 0x024 stores the data at the write pointer and advances that pointer. A read of 0x010 returns the word at the read pointer in the same access and advances that pointer.
- R4: Both pointers wrap from DEPTH-1 to 0. Status bit 0 is set when the write pointer wraps, and a software write to the write pointer clears it.
- R5: While control bit 0 is 1, every cycle with trc_valid high stores trc_data at the write pointer and advances it. While bit 0 is 0, trace input leaves the RAM and the pointers unchanged.
- R6: A software write to a pointer wins over an increment of that pointer in the same cycle.
- R7: With formatter control bit 13 set, the word that arrives with trc_trigger is stored without being counted. After that, exactly as many words as the trigger count holds are stored, the count steps down to 0, and capture halts. Further trace words are then dropped and formatter status bit 1 reads 1.
- R8: If formatting (formatter control bit 0) is on when a stop condition is reached and the write pointer is not a multiple of 4, zero words are written until it is, and only then does capture halt.
- R9: Writing 1 to formatter control bit 6 raises flush_req and makes bit 6 read 1. Once flush_ack is sampled high, flush_req and bit 6 clear at the second clock edge.
- R10: If formatter control bit 12 is set, a completed flush halts capture. If bit 12 is clear, a completed flush leaves capture running.
- R11: Formatter status bit 1 reads 1 whenever control bit 0 is 0 or capture has halted. Writing 1 to control bit 0 clears the halt and restarts capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Register bus select |
| bus_enable | input | 1 | Access phase; the access commits at the clock edge that ends it |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid during the access phase |
| trc_valid | input | 1 | A trace word is present |
| trc_data | input | 32 | Trace word |
| trc_trigger | input | 1 | Trigger marker that goes with the current trace word |
| flush_req | output | 1 | A manual flush is pending |
| flush_ack | input | 1 | The trace source has completed the flush |

## Verification
Register writes, RAM writes and trace words take effect at the edge that ends their access or valid cycle, so the bench reads them back only after that edge. Read data from 0x010 is combinational from the read pointer and is sampled inside the access phase. The read pointer then moves at the edge that ends that access.

A stop on trigger takes one idle edge after the last counted word, and each pad word takes one more edge. The bench therefore waits several cycles before it reads the pointers. flush_req is sampled at the falling edge after the first and after the second rising edge that follow the raising of flush_ack: it must still be high the first time and low the second time. All sampling and all input changes happen on falling edges.

// File: rtl/trs_pkg.sv
package trs_pkg;
  localparam logic [11:0] OFS_DEPTH  = 12'h004;
  localparam logic [11:0] OFS_STATUS = 12'h00C;
  localparam logic [11:0] OFS_RDATA  = 12'h010;
  localparam logic [11:0] OFS_RPTR   = 12'h014;
  localparam logic [11:0] OFS_WPTR   = 12'h018;
  localparam logic [11:0] OFS_TRGCNT = 12'h01C;
  localparam logic [11:0] OFS_CTRL   = 12'h020;
  localparam logic [11:0] OFS_WDATA  = 12'h024;
  localparam logic [11:0] OFS_FSTAT  = 12'h300;
  localparam logic [11:0] OFS_FCTRL  = 12'h304;

  localparam int BIT_RUN      = 0;
  localparam int BIT_FULL     = 0;
  localparam int BIT_FMT      = 0;
  localparam int BIT_FLUSH    = 6;
  localparam int BIT_STOPFLSH = 12;
  localparam int BIT_STOPTRIG = 13;
  localparam int BIT_STOPPED  = 1;

  localparam int FRAME_WORDS = 4;
  localparam int FRAME_BITS  = $clog2(FRAME_WORDS);
endpackage

// File: rtl/trs_ram.sv
module trs_ram #(
  parameter int DEPTH = 64,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/trs_ptrs.sv
module trs_ptrs #(
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rptr_ld,
  input  logic          wptr_ld,
  input  logic [AW-1:0] ld_val,
  input  logic          rptr_inc,
  input  logic          wptr_inc,
  output logic [AW-1:0] rptr,
  output logic [AW-1:0] wptr,
  output logic          full
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] rptr_d, wptr_d;
  logic          full_d;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : AW'(p + 1'b1);
  endfunction

  always_comb begin
    rptr_d = rptr;
    if (rptr_ld)       rptr_d = ld_val;
    else if (rptr_inc) rptr_d = step(rptr);

    wptr_d = wptr;
    full_d = full;
    if (wptr_ld) begin
      wptr_d = ld_val;
      full_d = 1'b0;
    end else if (wptr_inc) begin
      wptr_d = step(wptr);
      if (wptr == LAST) full_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr <= '0;
      wptr <= '0;
      full <= 1'b0;
    end else begin
      rptr <= rptr_d;
      wptr <= wptr_d;
      full <= full_d;
    end
  end
endmodule

// File: rtl/trs_ctrl.sv
module trs_ctrl
  import trs_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ctl_wr,
  input  logic                  trg_wr,
  input  logic                  fctl_wr,
  input  logic [31:0]           wdata,
  input  logic                  trc_valid,
  input  logic                  trc_trigger,
  input  logic                  flush_ack,
  input  logic                  sw_ram_we,
  input  logic [FRAME_BITS-1:0] wptr_lo,
  output logic                  cap_we,
  output logic                  pad_we,
  output logic                  ctl_run,
  output logic                  halt,
  output logic                  fmt_en,
  output logic                  stop_flush,
  output logic                  stop_trig,
  output logic                  flush_pend,
  output logic [31:0]           trg_cnt
);
  logic armed, padding, flush_done;
  logic ctl_run_d, halt_d, padding_d, armed_d, flush_pend_d, flush_done_d;
  logic fmt_en_d, stop_flush_d, stop_trig_d;
  logic [31:0] trg_cnt_d;
  logic stop_hit, running, aligned, stop_req;

  assign stop_hit = armed && (trg_cnt == '0);
  assign running  = ctl_run && !halt && !padding && !stop_hit;
  assign aligned  = (wptr_lo == '0);
  assign cap_we   = running && trc_valid && !sw_ram_we;
  assign pad_we   = padding && !aligned && !sw_ram_we;
  assign stop_req = (stop_hit || (flush_done && stop_flush)) && !halt && !padding;

  always_comb begin
    ctl_run_d    = ctl_run;
    halt_d       = halt;
    padding_d    = padding;
    armed_d      = armed;
    fmt_en_d     = fmt_en;
    stop_flush_d = stop_flush;
    stop_trig_d  = stop_trig;
    trg_cnt_d    = trg_cnt;
    flush_pend_d = flush_pend;
    flush_done_d = flush_pend && flush_ack && !flush_done;

    if (padding && aligned) begin
      padding_d = 1'b0;
      halt_d    = 1'b1;
    end
    if (stop_req) begin
      armed_d = 1'b0;
      if (fmt_en && !aligned) padding_d = 1'b1;
      else                    halt_d    = 1'b1;
    end
    if (running && trc_trigger && stop_trig && !armed) armed_d = 1'b1;

    if (trg_wr)                             trg_cnt_d = wdata;
    else if (armed && cap_we && trg_cnt != '0) trg_cnt_d = trg_cnt - 32'd1;

    if (fctl_wr) begin
      fmt_en_d     = wdata[BIT_FMT];
      stop_flush_d = wdata[BIT_STOPFLSH];
      stop_trig_d  = wdata[BIT_STOPTRIG];
    end
    if (flush_done)                        flush_pend_d = 1'b0;
    else if (fctl_wr && wdata[BIT_FLUSH])  flush_pend_d = 1'b1;

    if (ctl_wr) begin
      ctl_run_d = wdata[BIT_RUN];
      padding_d = 1'b0;
      if (wdata[BIT_RUN]) begin
        halt_d  = 1'b0;
        armed_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_run    <= 1'b0;
      halt       <= 1'b0;
      padding    <= 1'b0;
      armed      <= 1'b0;
      fmt_en     <= 1'b0;
      stop_flush <= 1'b0;
      stop_trig  <= 1'b0;
      trg_cnt    <= '0;
      flush_pend <= 1'b0;
      flush_done <= 1'b0;
    end else begin
      ctl_run    <= ctl_run_d;
      halt       <= halt_d;
      padding    <= padding_d;
      armed      <= armed_d;
      fmt_en     <= fmt_en_d;
      stop_flush <= stop_flush_d;
      stop_trig  <= stop_trig_d;
      trg_cnt    <= trg_cnt_d;
      flush_pend <= flush_pend_d;
      flush_done <= flush_done_d;
    end
  end
endmodule

// File: rtl/trace_ring_sink.sv
module trace_ring_sink
  import trs_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_enable,
  input  logic        bus_write,
  input  logic [11:0] bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        trc_valid,
  input  logic [31:0] trc_data,
  input  logic        trc_trigger,
  output logic        flush_req,
  input  logic        flush_ack
);
  localparam int AW = $clog2(DEPTH);

  logic [1:0] rst_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= '0;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_ni = rst_q[1];

  logic wr_acc, rd_acc;
  logic sw_ram_we, rptr_ld, wptr_ld, rptr_inc;
  logic ctl_wr, trg_wr, fctl_wr;
  logic cap_we, pad_we, ram_we;
  logic ctl_run, halt, fmt_en, stop_flush, stop_trig, flush_pend;
  logic [31:0] trg_cnt, ram_wdata, ram_rdata;
  logic [AW-1:0] rptr, wptr;
  logic full;

  assign wr_acc    = bus_sel && bus_enable && bus_write;
  assign rd_acc    = bus_sel && bus_enable && !bus_write;
  assign sw_ram_we = wr_acc && (bus_addr == OFS_WDATA);
  assign rptr_ld   = wr_acc && (bus_addr == OFS_RPTR);
  assign wptr_ld   = wr_acc && (bus_addr == OFS_WPTR);
  assign ctl_wr    = wr_acc && (bus_addr == OFS_CTRL);
  assign trg_wr    = wr_acc && (bus_addr == OFS_TRGCNT);
  assign fctl_wr   = wr_acc && (bus_addr == OFS_FCTRL);
  assign rptr_inc  = rd_acc && (bus_addr == OFS_RDATA);

  assign ram_we    = sw_ram_we || cap_we || pad_we;
  assign ram_wdata = sw_ram_we ? bus_wdata : (cap_we ? trc_data : '0);
  assign flush_req = flush_pend;

  trs_ram #(.DEPTH(DEPTH), .DW(32)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (wptr),
    .wdata (ram_wdata),
    .raddr (rptr),
    .rdata (ram_rdata)
  );

  trs_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk      (clk),
    .rst_n    (rst_ni),
    .rptr_ld  (rptr_ld),
    .wptr_ld  (wptr_ld),
    .ld_val   (bus_wdata[AW-1:0]),
    .rptr_inc (rptr_inc),
    .wptr_inc (ram_we),
    .rptr     (rptr),
    .wptr     (wptr),
    .full     (full)
  );

  trs_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_ni),
    .ctl_wr      (ctl_wr),
    .trg_wr      (trg_wr),
    .fctl_wr     (fctl_wr),
    .wdata       (bus_wdata),
    .trc_valid   (trc_valid),
    .trc_trigger (trc_trigger),
    .flush_ack   (flush_ack),
    .sw_ram_we   (sw_ram_we),
    .wptr_lo     (wptr[FRAME_BITS-1:0]),
    .cap_we      (cap_we),
    .pad_we      (pad_we),
    .ctl_run     (ctl_run),
    .halt        (halt),
    .fmt_en      (fmt_en),
    .stop_flush  (stop_flush),
    .stop_trig   (stop_trig),
    .flush_pend  (flush_pend),
    .trg_cnt     (trg_cnt)
  );

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      OFS_DEPTH:  bus_rdata = 32'(DEPTH);
      OFS_STATUS: bus_rdata[BIT_FULL] = full;
      OFS_RDATA:  bus_rdata = ram_rdata;
      OFS_RPTR:   bus_rdata = 32'(rptr);
      OFS_WPTR:   bus_rdata = 32'(wptr);
      OFS_TRGCNT: bus_rdata = trg_cnt;
      OFS_CTRL:   bus_rdata[BIT_RUN] = ctl_run;
      OFS_FSTAT:  bus_rdata[BIT_STOPPED] = !ctl_run || halt;
      OFS_FCTRL: begin
        bus_rdata[BIT_FMT]      = fmt_en;
        bus_rdata[BIT_FLUSH]    = flush_pend;
        bus_rdata[BIT_STOPFLSH] = stop_flush;
        bus_rdata[BIT_STOPTRIG] = stop_trig;
      end
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/trace_ring_sink_chk.sv
module trace_ring_sink_chk
  import trs_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ram_we,
  input logic          sw_ram_we,
  input logic          wptr_ld,
  input logic [AW-1:0] wptr,
  input logic          full,
  input logic          halt,
  input logic          fmt_en,
  input logic          flush_req,
  input logic          flush_ack
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  AST_FULL_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    wptr_ld |=> !full) else $error("full not cleared"); // R4

  AST_WPTR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && !wptr_ld) |=>
      (wptr == (($past(wptr) == LAST) ? '0 : AW'($past(wptr) + 1'b1))))
    else $error("write pointer step"); // R3

  AST_HALT_BLOCKS_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !sw_ram_we) |-> !ram_we) else $error("store while halted"); // R7

  AST_FLUSH_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flush_req) |-> $past(flush_ack, 2)) else $error("flush release"); // R9

  AST_HALT_ON_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(halt) && fmt_en) |-> (wptr[FRAME_BITS-1:0] == '0))
    else $error("halt off frame"); // R8
endmodule

bind trace_ring_sink trace_ring_sink_chk #(.DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_ni),
  .ram_we    (ram_we),
  .sw_ram_we (sw_ram_we),
  .wptr_ld   (wptr_ld),
  .wptr      (wptr),
  .full      (full),
  .halt      (halt),
  .fmt_en    (fmt_en),
  .flush_req (flush_req),
  .flush_ack (flush_ack)
);

// File: tb/trace_ring_sink_tb.sv
module trace_ring_sink_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel = 1'b0, bus_enable = 1'b0, bus_write = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        trc_valid = 1'b0, trc_trigger = 1'b0, flush_ack = 1'b0;
  logic [31:0] trc_data = '0;
  logic        flush_req;

  int n_chk = 0;
  int n_fail = 0;

  localparam logic [11:0] A_DEPTH = 12'h004, A_STAT = 12'h00C, A_RD = 12'h010,
                          A_RP = 12'h014, A_WP = 12'h018, A_TRG = 12'h01C,
                          A_CTL = 12'h020, A_WD = 12'h024, A_FS = 12'h300, A_FC = 12'h304;

  localparam logic [11:0] TA [8] = '{12'h01C, 12'h014, 12'h018, 12'h018,
                                     12'h304, 12'h304, 12'h020, 12'h004};
  localparam logic [31:0] TD [8] = '{32'h15, 32'd5, 32'd9, 32'd70,
                                     32'h3001, 32'h0, 32'h0, 32'h123};
  localparam logic [31:0] TE [8] = '{32'h15, 32'd5, 32'd9, 32'd6,
                                     32'h3001, 32'h0, 32'h0, 32'd64};

  always #5 clk = ~clk;

  trace_ring_sink u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_enable(bus_enable),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .trc_valid(trc_valid), .trc_data(trc_data),
    .trc_trigger(trc_trigger), .flush_req(flush_req), .flush_ack(flush_ack)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d; bus_enable = 1'b0;
    @(negedge clk);
    bus_enable = 1'b1;
    @(negedge clk);
    bus_sel = 1'b0; bus_enable = 1'b0; bus_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_write = 1'b0; bus_addr = a; bus_enable = 1'b0;
    @(negedge clk);
    bus_enable = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0; bus_enable = 1'b0;
  endtask

  task automatic rd_check(input string tag, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] v;
    bus_rd(a, v);
    check(tag, v, exp);
  endtask

  task automatic push(input logic [31:0] d, input logic trig);
    @(negedge clk);
    trc_valid = 1'b1; trc_data = d; trc_trigger = trig;
    @(negedge clk);
    trc_valid = 1'b0; trc_trigger = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd_check("R1 depth", A_DEPTH, 32'd64);
    rd_check("R1 status", A_STAT, 32'h0);
    rd_check("R1 ctl", A_CTL, 32'h0);
    rd_check("R1 rptr", A_RP, 32'h0);
    rd_check("R1 wptr", A_WP, 32'h0);
    rd_check("R1 fstat", A_FS, 32'h2);
    check("R1 flush_req", {31'b0, flush_req}, 32'h0);

    // R2 register table
    for (int i = 0; i < 8; i++) begin
      logic [31:0] v;
      bus_wr(TA[i], TD[i]);
      bus_rd(TA[i], v);
      check($sformatf("R2 entry %0d", i), v, TE[i]);
    end
    bus_wr(A_TRG, 32'h0);

    // R3 software RAM ports
    bus_wr(A_WP, 0);
    bus_wr(A_WD, 32'hA0A0_0001);
    bus_wr(A_WD, 32'hA0A0_0002);
    bus_wr(A_WD, 32'hA0A0_0003);
    rd_check("R3 wptr after 3", A_WP, 32'd3);
    bus_wr(A_RP, 0);
    rd_check("R3 word0", A_RD, 32'hA0A0_0001);
    rd_check("R3 word1", A_RD, 32'hA0A0_0002);
    rd_check("R3 word2", A_RD, 32'hA0A0_0003);
    rd_check("R3 rptr after 3", A_RP, 32'd3);

    // R4 wrap and full flag
    bus_wr(A_WP, 62);
    bus_wr(A_WD, 32'hB000_003E);
    bus_wr(A_WD, 32'hB000_003F);
    rd_check("R4 wptr wrapped", A_WP, 32'd0);
    rd_check("R4 full set", A_STAT, 32'h1);
    bus_wr(A_RP, 63);
    rd_check("R4 last word", A_RD, 32'hB000_003F);
    rd_check("R4 rptr wrapped", A_RP, 32'd0);
    bus_wr(A_WP, 0);
    rd_check("R4 full cleared", A_STAT, 32'h0);

    // R5 capture enable
    bus_wr(A_FC, 32'h0);
    bus_wr(A_CTL, 32'h1);
    rd_check("R11 running fstat", A_FS, 32'h0);
    for (int i = 0; i < 5; i++) push(32'hC000_0000 + i, 1'b0);
    rd_check("R5 wptr after 5", A_WP, 32'd5);
    bus_wr(A_CTL, 32'h0);
    push(32'hDEAD_BEEF, 1'b0);
    rd_check("R5 ignored when off", A_WP, 32'd5);
    rd_check("R11 off fstat", A_FS, 32'h2);
    bus_wr(A_RP, 0);
    rd_check("R5 word0", A_RD, 32'hC000_0000);
    rd_check("R5 word1", A_RD, 32'hC000_0001);

    // R6 pointer write wins over trace increment
    bus_wr(A_CTL, 32'h1);
    fork
      bus_wr(A_WP, 20);
      begin
        @(negedge clk);
        push(32'h6666_0000, 1'b0);
      end
    join
    rd_check("R6 wptr load wins", A_WP, 32'd20);
    bus_wr(A_CTL, 32'h0);

    // R7 stop on trigger, no formatting
    bus_wr(A_WP, 0);
    bus_wr(A_TRG, 32'd3);
    bus_wr(A_FC, 32'h2000);
    bus_wr(A_CTL, 32'h1);
    push(32'h7000_0000, 1'b0);
    push(32'h7000_0001, 1'b0);
    push(32'h7000_0002, 1'b1);
    for (int i = 3; i < 8; i++) push(32'h7000_0000 + i, 1'b0);
    repeat (3) @(negedge clk);
    rd_check("R7 wptr stops", A_WP, 32'd6);
    rd_check("R7 count zero", A_TRG, 32'd0);
    rd_check("R7 halted fstat", A_FS, 32'h2);
    rd_check("R7 ctl still set", A_CTL, 32'h1);

    // R8 pad to frame boundary
    bus_wr(A_FC, 32'h2001);
    bus_wr(A_WP, 0);
    bus_wr(A_TRG, 32'd2);
    bus_wr(A_CTL, 32'h1);
    push(32'h8000_0000, 1'b1);
    push(32'h8000_0001, 1'b0);
    push(32'h8000_0002, 1'b0);
    repeat (6) @(negedge clk);
    rd_check("R8 wptr padded", A_WP, 32'd4);
    bus_wr(A_RP, 3);
    rd_check("R8 pad word zero", A_RD, 32'h0);
    rd_check("R8 halted fstat", A_FS, 32'h2);

    // R9 / R10 manual flush with stop
    bus_wr(A_FC, 32'h0);
    bus_wr(A_CTL, 32'h1);
    rd_check("R11 restart fstat", A_FS, 32'h0);
    bus_wr(A_FC, 32'h1040);
    check("R9 flush_req high", {31'b0, flush_req}, 32'h1);
    rd_check("R9 bit6 reads 1", A_FC, 32'h1040);
    @(negedge clk); flush_ack = 1'b1;
    @(negedge clk);
    check("R9 req after 1 edge", {31'b0, flush_req}, 32'h1);
    @(negedge clk);
    check("R9 req after 2 edges", {31'b0, flush_req}, 32'h0);
    flush_ack = 1'b0;
    rd_check("R9 bit6 cleared", A_FC, 32'h1000);
    rd_check("R10 halted by flush", A_FS, 32'h2);

    // R10 flush without stop keeps running
    bus_wr(A_CTL, 32'h1);
    bus_wr(A_FC, 32'h0040);
    @(negedge clk); flush_ack = 1'b1;
    repeat (2) @(negedge clk);
    flush_ack = 1'b0;
    repeat (2) @(negedge clk);
    check("R10 req dropped", {31'b0, flush_req}, 32'h0);
    rd_check("R10 still running", A_FS, 32'h0);

    finish_run();
  end
endmodule